// File: doc/BRIEF.md
# Redundant Fabric Link Interface

This block sits between one network-processor datapath and a pair of redundant switch-fabric links, called A and B. On the transmit side, each word from the network processor goes out on both fabric links in the same cycle, so either fabric can carry the traffic. On the receive side, each link has its own FIFO. A single registered select then chooses which FIFO feeds the network processor. One mux decision covers every lane of the word, so the lanes always switch together.

Both receive FIFOs accept words from their links at all times. The standby copy therefore stays current, and a switchover can continue from the standby FIFO's head. On a switchover, the FIFO that was active until then is flushed. Each FIFO is eight words deep. When a word arrives at a full FIFO and nothing is read that cycle, the FIFO drops its oldest word and sets a sticky overflow flag. The links are assumed to be deskewed, aligned to each other, and clocked from the same reference as this block.

Top module: `fabric_link_redund`

## Requirements
- R1: In every cycle, `fab_a_tx_data` and `fab_b_tx_data` equal `np_tx_data`, and `fab_a_tx_valid` and `fab_b_tx_valid` equal `np_tx_valid`. There is no register delay on this path.
- R2: After a synchronous reset (`rst_n` low at a clock edge), the block is in this state: `active_b`=0 (link A active), `swap_count`=0, `np_rx_valid`=0, `ovf_a`=0 and `ovf_b`=0.
- R3: `sel_b` (0 selects A, 1 selects B) is sampled at each clock edge. `active_b` shows the sampled value from the next cycle on. All lanes of `np_rx_data` come from the FIFO named by `active_b`.
- R4: Each FIFO returns its link's valid words in arrival order. The active FIFO advances by one word only in a cycle where `np_rx_ready` and `np_rx_valid` are both 1.
- R5: The FIFO that is not active keeps storing words from its link, and `np_rx_ready` never removes words from it.
- R6: A FIFO holds at most 8 words. If a word arrives at a full FIFO and no read happens in that cycle, the oldest word is discarded and the link's overflow flag (`ovf_a` or `ovf_b`) is set. The flag stays set until reset.
- R7: At a switchover edge, the FIFO that was active is emptied. A word arriving on its link in that same cycle is kept as its only content. Any read request in that cycle is ignored. From the next cycle, the newly active FIFO is presented from its current head.
- R8: `swap_count` increases by one at each edge where `sel_b` differs from `active_b`. It wraps modulo 2^8.
- R9: `np_rx_valid` is 1 exactly when the active FIFO holds at least one word, and `np_rx_data` is then that FIFO's oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with both links |
| rst_n | input | 1 | Synchronous reset, active low |
| np_tx_data | input | 32 | Word from the network processor, 4 lanes of 8 bits |
| np_tx_valid | input | 1 | `np_tx_data` is valid |
| fab_a_tx_data | output | 32 | Transmit word toward fabric A |
| fab_a_tx_valid | output | 1 | Valid flag toward fabric A |
| fab_b_tx_data | output | 32 | Transmit word toward fabric B |
| fab_b_tx_valid | output | 1 | Valid flag toward fabric B |
| lnk_a_rx_data | input | 32 | Aligned receive word from link A |
| lnk_a_rx_valid | input | 1 | Link A word is valid |
| lnk_b_rx_data | input | 32 | Aligned receive word from link B |
| lnk_b_rx_valid | input | 1 | Link B word is valid |
| sel_b | input | 1 | Requested active link: 0 selects A, 1 selects B |
| np_rx_ready | input | 1 | Network processor accepts the presented word |
| np_rx_data | output | 32 | Head word of the active FIFO |
| np_rx_valid | output | 1 | The active FIFO is not empty |
| active_b | output | 1 | Link currently active: 0 is A, 1 is B |
| swap_count | output | 8 | Number of completed switchovers, wrapping |
| ovf_a | output | 1 | Sticky overflow flag for link A |
| ovf_b | output | 1 | Sticky overflow flag for link B |

## Verification
A wrong FIFO pointer or a wrong occupancy count shows at the ports within one cycle: a stale word, a duplicated word or a skipped word appears on `np_rx_data`, or `np_rx_valid` is wrong. For the standby FIFO, the same fault only becomes visible after the next switchover. A fault in the select or flush logic shows up when the first word after the switch comes from the wrong link, or when old words reappear after a switch back. Overflow faults show as a sticky flag that is wrong from the following cycle, or as a word missing from the drained sequence.

// File: rtl/frl_pkg.sv
// Package: shared types for the redundant fabric link interface.
// Assumes: two links only, identified by one bit.
package frl_pkg;
    typedef enum logic {
        LINK_A = 1'b0,
        LINK_B = 1'b1
    } link_id_t;
endpackage

// File: rtl/frl_tx_fanout.sv
// Module: frl_tx_fanout
// Purpose: copies the network-processor transmit word to both fabric links
//          in the same cycle.
// Assumes: both fabrics accept a word every cycle; there is no backpressure.
module frl_tx_fanout #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_data,
    input  logic         src_valid,
    output logic [W-1:0] dst_a_data,
    output logic         dst_a_valid,
    output logic [W-1:0] dst_b_data,
    output logic         dst_b_valid
);
    // Purpose: combinational replication of the word and its valid flag.
    always_comb begin
        dst_a_data  = src_data;
        dst_a_valid = src_valid;
        dst_b_data  = src_data;
        dst_b_valid = src_valid;
    end
endmodule

// File: rtl/frl_rx_buffer.sv
// Module: frl_rx_buffer
// Purpose: per-link receive FIFO. When full, a new word replaces the oldest
//          word and a sticky overflow flag is set. A flush empties the FIFO
//          but keeps a word written in the same cycle.
// Assumes: DEPTH is a power of two; flush takes priority over pop.
module frl_rx_buffer #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic [$clog2(DEPTH):0] level,
    output logic             ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_pop, full, drop;
    logic [AW-1:0] wr_addr;

    // Purpose: decode this cycle's pop, drop-oldest and write address.
    always_comb begin
        full    = (cnt == FULL_LVL);
        do_pop  = pop && (cnt != '0) && !flush;
        drop    = push && full && !do_pop && !flush;
        wr_addr = flush ? '0 : wr_ptr;
    end

    // Purpose: storage write; holds data only, so it has no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_addr] <= din;
    end

    // Purpose: pointer, occupancy and sticky-flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= push ? AW'(1) : '0;
            cnt    <= push ? (AW+1)'(1) : '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop || drop) rd_ptr <= rd_ptr + AW'(1);
            if (!drop)
                cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, do_pop};
            if (drop) ovf <= 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign level = cnt;
endmodule

// File: rtl/frl_rx_select.sv
// Module: frl_rx_select
// Purpose: keeps the registered active-link choice and the switchover
//          counter. It steers read and flush to the two FIFOs and muxes all
//          lanes of the word together from the active FIFO.
// Assumes: a switchover happens on a clock edge, so only whole words move.
module frl_rx_select
    import frl_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_req,
    input  logic                    rdy,
    input  logic [LANES*LANE_W-1:0] head_a,
    input  logic                    empty_a,
    input  logic [LANES*LANE_W-1:0] head_b,
    input  logic                    empty_b,
    output logic                    pop_a,
    output logic                    pop_b,
    output logic                    flush_a,
    output logic                    flush_b,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic                    out_valid,
    output logic                    act_b,
    output logic [CNT_W-1:0]        swaps
);
    link_id_t act_q;
    logic     swap;

    // Purpose: detect a switchover and route read and flush to the FIFOs.
    always_comb begin
        swap      = (link_id_t'(sel_req) != act_q);
        out_valid = (act_q == LINK_A) ? !empty_a : !empty_b;
        pop_a     = rdy && out_valid && (act_q == LINK_A);
        pop_b     = rdy && out_valid && (act_q == LINK_B);
        flush_a   = swap && (act_q == LINK_A);
        flush_b   = swap && (act_q == LINK_B);
    end

    // Purpose: register the active link and count switchovers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= LINK_A;
            swaps <= '0;
        end else if (swap) begin
            act_q <= link_id_t'(sel_req);
            swaps <= swaps + CNT_W'(1);
        end
    end

    // Purpose: one shared select drives the mux of every lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign out_data[l*LANE_W +: LANE_W] = (act_q == LINK_B)
            ? head_b[l*LANE_W +: LANE_W] : head_a[l*LANE_W +: LANE_W];
    end

    assign act_b = (act_q == LINK_B);
endmodule

// File: rtl/fabric_link_redund.sv
// Module: fabric_link_redund (top)
// Purpose: redundant switch-fabric interface. Transmit words go to both
//          fabrics; receive words are buffered per link and one link is
//          forwarded, chosen by a registered select.
// Assumes: links are aligned and deskewed, and share this block's clock.
module fabric_link_redund #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] np_tx_data,
    input  logic                    np_tx_valid,
    output logic [LANES*LANE_W-1:0] fab_a_tx_data,
    output logic                    fab_a_tx_valid,
    output logic [LANES*LANE_W-1:0] fab_b_tx_data,
    output logic                    fab_b_tx_valid,
    input  logic [LANES*LANE_W-1:0] lnk_a_rx_data,
    input  logic                    lnk_a_rx_valid,
    input  logic [LANES*LANE_W-1:0] lnk_b_rx_data,
    input  logic                    lnk_b_rx_valid,
    input  logic                    sel_b,
    input  logic                    np_rx_ready,
    output logic [LANES*LANE_W-1:0] np_rx_data,
    output logic                    np_rx_valid,
    output logic                    active_b,
    output logic [CNT_W-1:0]        swap_count,
    output logic                    ovf_a,
    output logic                    ovf_b
);
    localparam int W  = LANES * LANE_W;
    localparam int LW = $clog2(DEPTH) + 1;

    logic [W-1:0]  head_a, head_b;
    logic          empty_a, empty_b;
    logic          pop_a, pop_b, flush_a, flush_b;
    logic [LW-1:0] a_level, b_level;

    frl_tx_fanout #(.W(W)) u_tx (
        .src_data   (np_tx_data),
        .src_valid  (np_tx_valid),
        .dst_a_data (fab_a_tx_data),
        .dst_a_valid(fab_a_tx_valid),
        .dst_b_data (fab_b_tx_data),
        .dst_b_valid(fab_b_tx_valid)
    );

    frl_rx_buffer #(.W(W), .DEPTH(DEPTH)) u_buf_a (
        .clk(clk), .rst_n(rst_n),
        .push(lnk_a_rx_valid), .din(lnk_a_rx_data),
        .pop(pop_a), .flush(flush_a),
        .head(head_a), .empty(empty_a), .level(a_level), .ovf(ovf_a)
    );

    frl_rx_buffer #(.W(W), .DEPTH(DEPTH)) u_buf_b (
        .clk(clk), .rst_n(rst_n),
        .push(lnk_b_rx_valid), .din(lnk_b_rx_data),
        .pop(pop_b), .flush(flush_b),
        .head(head_b), .empty(empty_b), .level(b_level), .ovf(ovf_b)
    );

    frl_rx_select #(.LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .sel_req(sel_b), .rdy(np_rx_ready),
        .head_a(head_a), .empty_a(empty_a),
        .head_b(head_b), .empty_b(empty_b),
        .pop_a(pop_a), .pop_b(pop_b),
        .flush_a(flush_a), .flush_b(flush_b),
        .out_data(np_rx_data), .out_valid(np_rx_valid),
        .act_b(active_b), .swaps(swap_count)
    );
endmodule

// File: rtl/frl_checker.sv
// Module: frl_checker
// Purpose: assertions on the redundant fabric link interface, bound to the top.
// Assumes: it is attached with the bind statement at the end of this file.
module frl_checker #(
    parameter int W     = 32,
    parameter int LW    = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     np_tx_data,
    input logic             np_tx_valid,
    input logic [W-1:0]     fab_a_tx_data,
    input logic             fab_a_tx_valid,
    input logic [W-1:0]     fab_b_tx_data,
    input logic             fab_b_tx_valid,
    input logic             lnk_a_rx_valid,
    input logic             lnk_b_rx_valid,
    input logic             sel_b,
    input logic             active_b,
    input logic [CNT_W-1:0] swap_count,
    input logic             ovf_a,
    input logic             ovf_b,
    input logic [LW-1:0]    a_level,
    input logic [LW-1:0]    b_level
);
    // R1: both fabrics carry the network-processor word in the same cycle
    assert_tx_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_a_tx_data == np_tx_data) && (fab_b_tx_data == np_tx_data) &&
        (fab_a_tx_valid == np_tx_valid) && (fab_b_tx_valid == np_tx_valid));

    // R3: the active link follows the select one edge later
    assert_active_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (active_b == $past(sel_b)));

    // R8: a differing select increments the counter by one
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != active_b) |=> (swap_count == $past(swap_count) + CNT_W'(1)));

    // R8: no switchover means the counter holds
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == active_b) |=> $stable(swap_count));

    // R6: overflow flags are sticky
    assert_ovf_sticky_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_a |=> ovf_a);
    assert_ovf_sticky_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_b |=> ovf_b);

    // R7: leaving A empties its FIFO, apart from a word arriving that cycle
    assert_flush_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b && !active_b) |=> (a_level == LW'($past(lnk_a_rx_valid))));

    // R5: the standby FIFO never shrinks while its link is idle and no switchover happens
    assert_standby_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_b && !sel_b && !lnk_b_rx_valid) |=> (b_level == $past(b_level)));
endmodule

bind fabric_link_redund frl_checker #(
    .W(LANES*LANE_W), .LW($clog2(DEPTH)+1), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .np_tx_data(np_tx_data), .np_tx_valid(np_tx_valid),
    .fab_a_tx_data(fab_a_tx_data), .fab_a_tx_valid(fab_a_tx_valid),
    .fab_b_tx_data(fab_b_tx_data), .fab_b_tx_valid(fab_b_tx_valid),
    .lnk_a_rx_valid(lnk_a_rx_valid), .lnk_b_rx_valid(lnk_b_rx_valid),
    .sel_b(sel_b), .active_b(active_b), .swap_count(swap_count),
    .ovf_a(ovf_a), .ovf_b(ovf_b),
    .a_level(a_level), .b_level(b_level)
);

// File: tb/fabric_link_redund_tb.sv
`timescale 1ns/1ps
// Bench: fabric_link_redund_tb. Inputs are driven at the falling edge; a
// queue model built from the requirements is updated after each rising edge.
module fabric_link_redund_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] np_tx_data = '0;
    logic        np_tx_valid = 1'b0;
    logic [31:0] fab_a_tx_data, fab_b_tx_data;
    logic        fab_a_tx_valid, fab_b_tx_valid;
    logic [31:0] lnk_a_rx_data = '0, lnk_b_rx_data = '0;
    logic        lnk_a_rx_valid = 1'b0, lnk_b_rx_valid = 1'b0;
    logic        sel_b = 1'b0, np_rx_ready = 1'b0;
    logic [31:0] np_rx_data;
    logic        np_rx_valid, active_b, ovf_a, ovf_b;
    logic [7:0]  swap_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] qa[$];
    logic [31:0] qb[$];
    logic        m_act = 1'b0;
    logic [7:0]  m_cnt = '0;
    logic        m_ova = 1'b0, m_ovb = 1'b0;

    always #2.5 clk = ~clk;

    fabric_link_redund u_dut (
        .clk(clk), .rst_n(rst_n),
        .np_tx_data(np_tx_data), .np_tx_valid(np_tx_valid),
        .fab_a_tx_data(fab_a_tx_data), .fab_a_tx_valid(fab_a_tx_valid),
        .fab_b_tx_data(fab_b_tx_data), .fab_b_tx_valid(fab_b_tx_valid),
        .lnk_a_rx_data(lnk_a_rx_data), .lnk_a_rx_valid(lnk_a_rx_valid),
        .lnk_b_rx_data(lnk_b_rx_data), .lnk_b_rx_valid(lnk_b_rx_valid),
        .sel_b(sel_b), .np_rx_ready(np_rx_ready),
        .np_rx_data(np_rx_data), .np_rx_valid(np_rx_valid),
        .active_b(active_b), .swap_count(swap_count),
        .ovf_a(ovf_a), .ovf_b(ovf_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Model of one FIFO edge: flush, pop, push, drop-oldest
    task automatic model_buf(inout logic [31:0] q[$], inout logic ov,
                             input logic push, input logic [31:0] d,
                             input logic pop, input logic flush);
        if (flush) begin
            q.delete();
            if (push) q.push_back(d);
        end else begin
            if (pop && q.size() > 0) void'(q.pop_front());
            if (push) begin
                if (q.size() == 8) begin
                    void'(q.pop_front());
                    ov = 1'b1;
                end
                q.push_back(d);
            end
        end
    endtask

    // One cycle: drive at the falling edge, check outputs, model the rising edge
    task automatic cycle(input logic av, input logic [31:0] ad,
                         input logic bv, input logic [31:0] bd,
                         input logic sel, input logic rdy, input logic [31:0] tx);
        logic swap;
        logic [31:0] hd;
        lnk_a_rx_valid = av; lnk_a_rx_data = ad;
        lnk_b_rx_valid = bv; lnk_b_rx_data = bd;
        sel_b = sel; np_rx_ready = rdy;
        np_tx_data = tx; np_tx_valid = tx[0];
        #0.5;
        chk("R1 tx A data", fab_a_tx_data, tx);
        chk("R1 tx B data", fab_b_tx_data, tx);
        chk("R1 tx valid", {fab_a_tx_valid, fab_b_tx_valid}, {tx[0], tx[0]});
        chk("R3 active link", active_b, m_act);
        chk("R8 swap count", swap_count, m_cnt);
        chk("R6 overflow flags", {ovf_a, ovf_b}, {m_ova, m_ovb});
        if (!m_act) begin
            chk("R9 rx valid", np_rx_valid, qa.size() > 0);
            if (qa.size() > 0) begin hd = qa[0]; chk("R4 rx data from A", np_rx_data, hd); end
        end else begin
            chk("R9 rx valid", np_rx_valid, qb.size() > 0);
            if (qb.size() > 0) begin hd = qb[0]; chk("R4 rx data from B", np_rx_data, hd); end
        end
        @(posedge clk);
        swap = (sel != m_act);
        model_buf(qa, m_ova, av, ad, rdy && !m_act, swap && !m_act);
        model_buf(qb, m_ovb, bv, bd, rdy && m_act, swap && m_act);
        if (swap) m_cnt = m_cnt + 8'd1;
        m_act = sel;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R2: reset state
        chk("R2 reset active", active_b, 1'b0);
        chk("R2 reset count", swap_count, 8'd0);
        chk("R2 reset valid", np_rx_valid, 1'b0);
        chk("R2 reset ovf", {ovf_a, ovf_b}, 2'b00);
        @(negedge clk);

        // R4 R5: fill A in order, B fills in standby; drain A
        for (int i = 0; i < 6; i++)
            cycle(1, 32'hA0A0_0000 + 32'(i*257), 1, 32'hB0B0_0000 + 32'(i*771), 0, 0, 32'(i));
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, 1, 0);
        chk("R5 standby held", 64'(qb.size()), 64'd6);

        // R7: switch to B; B is read from its head and A is flushed
        cycle(0, 0, 0, 0, 1, 1, 0);
        chk("R7 new head from B", np_rx_data, 32'hB0B0_0000);
        cycle(0, 0, 0, 0, 0, 0, 0);
        chk("R7 A flushed", np_rx_valid, 1'b0);
        cycle(0, 0, 0, 0, 1, 0, 0);
        chk("R7 B flushed too", np_rx_valid, 1'b0);

        // R6: overflow on both links with no reads
        for (int i = 0; i < 12; i++)
            cycle(1, 32'h1100_0000 + 32'(i), 1, 32'h2200_0000 + 32'(i), 1, 0, 32'(i));
        chk("R6 oldest dropped", np_rx_data, 32'h2200_0004);
        chk("R6 flags set", {ovf_a, ovf_b}, 2'b11);
        for (int i = 0; i < 10; i++) cycle(0, 0, 0, 0, 1, 1, 0);

        // R8: long toggling run, wraps past 255
        for (int i = 0; i < 300; i++)
            cycle(i[1], 32'h3300_0000 + 32'(i), i[2], 32'h4400_0000 + 32'(i),
                  i[0], i[3], 32'(i * 3));
        chk("R8 wrapped count", swap_count, 8'(m_cnt));

        // Near-exhaustive sweep over valid/select/ready patterns
        for (int i = 0; i < 6000; i++) begin
            int s = (i * 7919) ^ (i >> 3);
            cycle(s[0] | s[5], 32'(s * 13),
                  s[1] & ~s[6], 32'(s * 29 + 5),
                  (i / 41) % 2 == 1, s[2] & s[4] | s[7], 32'(s));
        end

        // R2: reset again mid-traffic
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R2 second reset", {active_b, np_rx_valid, ovf_a, ovf_b}, 4'b0000);
        chk("R2 second reset count", swap_count, 8'd0);

        summary();
        $finish;
    end
endmodule